// File: doc/BRIEF.md
# Parity-Guarded Microinstruction Store

This block holds microinstructions that are 34 bits wide. Each instruction is kept as two independent 17-bit halves. The upper half is instruction bits [33:17] and the lower half is bits [16:0]. Every half carries its own stored parity bit.

Software writes one half at a time through a valid/ready port. The port takes a 16-bit data word, one extra seventeenth bit, and the two byte-parity bits that travel with the 16-bit word. The stored parity is formed from those byte-parity bits and the extra bit, not from the data itself. A force-bad control inverts the stored bit, so a half can be planted with deliberately wrong parity. When both halves of an entry are poisoned this way, the entry acts as a breakpoint.

On the fetch side, the word at the fetch address is checked combinationally on both halves, and that per-half result is shown live. When fetch is asserted, the clock edge loads the instruction register. The same edge captures the per-half check result, a breakpoint flag and a sticky halt, each half having its own halt enable. A hold-on-error debug mode keeps the instruction register from being overwritten when the fetched word fails its check, so the failing instruction is preserved.

Top module: `micro_store_par`

## Requirements
- R1: The write port accepts a beat when `wr_valid` and `wr_ready` are both high. `wr_ready` is low in any cycle where `fetch_en` is high, so fetch always wins, and a refused beat changes nothing. `wr_sel` = 1 selects the upper half and 0 the lower half. `wr_data` fills bits [15:0] of the half and `wr_ext` fills bit 16.
- R2: Each byte-parity input is odd parity for its byte: `wr_bpar[1]` covers `wr_data[15:8]` and `wr_bpar[0]` covers `wr_data[7:0]`. The stored bit is the inverse of `wr_bpar[1]^wr_bpar[0]^wr_ext`. With correct byte parity, the 17 data bits plus the stored bit then hold an odd count of ones.
- R3: With `wr_force_bad` high, the stored bit is inverted. The other half of the same entry is left untouched.
- R4: `live_err[1]` (upper) and `live_err[0]` (lower) are combinational. Each is high when that half at `fetch_addr`, together with its stored bit, holds an even count of ones.
- R5: On a clock edge with `fetch_en` high and no hold, `mir` takes the 34 data bits at `fetch_addr`. On every fetch edge, `err_latched` takes `live_err`. Both keep their values between fetches.
- R6: `halt` sets on a fetch edge where any half is bad and that half's bit in `halt_en` is 1. It then stays high until reset.
- R7: On a fetch edge where both halves are bad, `brkpt` goes high and `err_latched` shows 2'b11. The next fetch edge where the two halves are not both bad clears `brkpt`.
- R8: With `dbg_hold` high, a fetch edge with any bad half leaves `mir` unchanged, while `err_latched`, `brkpt` and `halt` still update.
- R9: While `rst_n` is low, `mir`, `err_latched`, `brkpt` and `halt` are zero. Stored words are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat can be taken (low during fetch) |
| wr_sel | input | 1 | Half select: 1 upper, 0 lower |
| wr_addr | input | AW | Entry written |
| wr_data | input | DATA_W | Low 16 bits of the half |
| wr_ext | input | 1 | Bit 16 of the half |
| wr_bpar | input | DATA_W/8 | Odd parity of each byte of wr_data |
| wr_force_bad | input | 1 | Store inverted parity |
| fetch_en | input | 1 | Load the instruction register this edge |
| fetch_addr | input | AW | Entry fetched |
| dbg_hold | input | 1 | Keep the instruction register on a bad fetch |
| halt_en | input | 2 | Halt enable per half (bit 1 upper) |
| live_err | output | 2 | Unlatched per-half parity failure at fetch_addr |
| mir | output | 2*(DATA_W+1) | Instruction register |
| err_latched | output | 2 | Per-half failure captured at the last fetch |
| brkpt | output | 1 | Both halves failed at the last fetch |
| halt | output | 1 | Sticky error halt |

## Verification
The assertions assume that every entry the fetch side reads has been written at least once since power-up, because unwritten words carry unknown parity. They also assume that `fetch_en`, `dbg_hold` and `halt_en` are stable across the sampling edge. The stimulus fills every entry of both halves before the first fetch. It then changes inputs only on the falling clock edge. Random writes mostly carry correct byte parity, with occasional corrupted byte-parity bits and forced-bad writes, so both clean and failing fetches keep occurring.

// File: rtl/mis_pkg.sv
package mis_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  typedef struct packed {
    logic [1:0] err;
    logic       brk;
    logic       halt;
  } ir_status_t;
endpackage

// File: rtl/mis_par_check.sv
module mis_par_check #(
  parameter int W = 17
) (
  input  logic [W-1:0] word,
  input  logic         par,
  output logic         bad
);
  // good half: odd count of ones over data and stored bit
  assign bad = ~(^{word, par});
endmodule

// File: rtl/mis_half_store.sv
module mis_half_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_ext,
  input  logic [DATA_W/8-1:0] wr_bpar,
  input  logic                wr_force_bad,
  input  logic [AW-1:0]       rd_addr,
  output logic [DATA_W:0]     rd_word,
  output logic                rd_par
);
  localparam int  BYTES    = DATA_W / 8;
  localparam logic ODD_CNT = 1'(BYTES % 2);

  logic [DATA_W:0] mem_d [DEPTH];
  logic            mem_p [DEPTH];
  logic            par_in;

  // xor of odd byte parities equals data parity when byte count is even
  always_comb par_in = ~((^wr_bpar) ^ ODD_CNT ^ wr_ext) ^ wr_force_bad;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_d[wr_addr] <= {wr_ext, wr_data};
      mem_p[wr_addr] <= par_in;
    end
  end

  assign rd_word = mem_d[rd_addr];
  assign rd_par  = mem_p[rd_addr];
endmodule

// File: rtl/mis_ir_stage.sv
module mis_ir_stage #(
  parameter int IW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en,
  input  logic          dbg_hold,
  input  logic [1:0]    halt_en,
  input  logic [IW-1:0] rd_word,
  input  logic [1:0]    live_bad,
  output logic [IW-1:0] mir,
  output mis_pkg::ir_status_t status
);
  logic any_bad, block;

  always_comb begin
    any_bad = |live_bad;
    block   = dbg_hold & any_bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mir    <= '0;
      status <= '0;
    end else if (fetch_en) begin
      if (!block) mir <= rd_word;
      status.err  <= live_bad;
      status.brk  <= &live_bad;
      status.halt <= status.halt | (|(live_bad & halt_en));
    end
  end

  assert_hold_keeps_ir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && dbg_hold && |live_bad) |=> $stable(mir));

  assert_ir_loads_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && !(dbg_hold && |live_bad)) |=> (mir == $past(rd_word)));

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status.halt |=> status.halt);

  assert_double_fail_breaks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && &live_bad) |=> (status.brk && status.err == 2'b11));
endmodule

// File: rtl/micro_store_par.sv
module micro_store_par #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 16,
  parameter int AW     = $clog2(DEPTH),
  parameter int HW     = DATA_W + 1,
  parameter int IW     = 2 * HW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic                wr_sel,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                wr_ext,
  input  logic [DATA_W/8-1:0] wr_bpar,
  input  logic                wr_force_bad,
  input  logic                fetch_en,
  input  logic [AW-1:0]       fetch_addr,
  input  logic                dbg_hold,
  input  logic [1:0]          halt_en,
  output logic [1:0]          live_err,
  output logic [IW-1:0]       mir,
  output logic [1:0]          err_latched,
  output logic                brkpt,
  output logic                halt
);
  import mis_pkg::*;

  logic [IW-1:0] rd_word;
  logic [1:0]    rd_par;
  logic [1:0]    half_bad;
  logic          accept;
  ir_status_t    st;

  assign wr_ready = ~fetch_en;
  assign accept   = wr_valid & wr_ready;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic wr_en_h;
    assign wr_en_h = accept & (wr_sel == ((h == 1) ? HALF_HI : HALF_LO));

    mis_half_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_store (
      .clk          (clk),
      .wr_en        (wr_en_h),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .wr_ext       (wr_ext),
      .wr_bpar      (wr_bpar),
      .wr_force_bad (wr_force_bad),
      .rd_addr      (fetch_addr),
      .rd_word      (rd_word[h*HW +: HW]),
      .rd_par       (rd_par[h])
    );

    mis_par_check #(.W(HW)) u_chk (
      .word (rd_word[h*HW +: HW]),
      .par  (rd_par[h]),
      .bad  (half_bad[h])
    );
  end

  assign live_err = half_bad;

  mis_ir_stage #(.IW(IW)) u_ir (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_en (fetch_en),
    .dbg_hold (dbg_hold),
    .halt_en  (halt_en),
    .rd_word  (rd_word),
    .live_bad (half_bad),
    .mir      (mir),
    .status   (st)
  );

  assign err_latched = st.err;
  assign brkpt       = st.brk;
  assign halt        = st.halt;

  assert_halt_needs_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(fetch_en));
endmodule

// File: tb/micro_store_par_test.sv
module micro_store_par_test;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0, wr_sel = 0, wr_ext = 0, wr_force_bad = 0;
  logic [AW-1:0] wr_addr = '0, fetch_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] wr_bpar = '0, halt_en = '0;
  logic fetch_en = 0, dbg_hold = 0;
  logic wr_ready, brkpt, halt;
  logic [1:0] live_err, err_latched;
  logic [33:0] mir;

  micro_store_par uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ext(wr_ext),
    .wr_bpar(wr_bpar), .wr_force_bad(wr_force_bad), .fetch_en(fetch_en),
    .fetch_addr(fetch_addr), .dbg_hold(dbg_hold), .halt_en(halt_en),
    .live_err(live_err), .mir(mir), .err_latched(err_latched),
    .brkpt(brkpt), .halt(halt)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [16:0] ref_d [2][DEPTH];
  logic        ref_bad [2][DEPTH];
  logic [33:0] exp_mir;
  logic [1:0]  exp_err;
  logic        exp_brk, exp_halt;

  task automatic check(string req, logic [33:0] act, logic [33:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] good_bpar(logic [15:0] d);
    return {~^d[15:8], ~^d[7:0]};
  endfunction

  // R2/R3 model: stored bit from byte parity and extra bit, inverted by force
  function automatic logic stored_par(logic [1:0] bp, logic ext, logic frc);
    return ~(bp[1] ^ bp[0] ^ ext) ^ frc;
  endfunction

  function automatic logic half_is_bad(logic [16:0] d, logic p);
    return ~(^{d, p});
  endfunction

  task automatic do_write(logic sel, logic [AW-1:0] a, logic [15:0] d,
                          logic ext, logic [1:0] bp, logic frc);
    @(negedge clk);
    fetch_en = 0; wr_valid = 1; wr_sel = sel; wr_addr = a; wr_data = d;
    wr_ext = ext; wr_bpar = bp; wr_force_bad = frc;
    @(posedge clk);
    ref_d[sel][a] = {ext, d};
    ref_bad[sel][a] = half_is_bad({ext, d}, stored_par(bp, ext, frc));
  endtask

  task automatic do_fetch(logic [AW-1:0] a, logic dbg, logic [1:0] hen);
    logic [1:0] b;
    @(negedge clk);
    wr_valid = 0; fetch_en = 1; fetch_addr = a; dbg_hold = dbg; halt_en = hen;
    #1;
    b = {ref_bad[1][a], ref_bad[0][a]};
    check("R4 live_err", 34'(live_err), 34'(b));
    @(posedge clk);
    if (!(dbg && |b)) exp_mir = {ref_d[1][a], ref_d[0][a]};
    exp_err = b;
    exp_brk = &b;
    exp_halt = exp_halt | (|(b & hen));
    @(negedge clk);
    fetch_en = 0;
    check("R5/R8 mir", mir, exp_mir);
    check("R5 err_latched", 34'(err_latched), 34'(exp_err));
    check("R7 brkpt", 34'(brkpt), 34'(exp_brk));
    check("R6 halt", 34'(halt), 34'(exp_halt));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; fetch_en = 0; wr_valid = 0;
    @(negedge clk);
    check("R9 mir reset", mir, '0);
    check("R9 status reset", 34'({err_latched, brkpt, halt}), '0);
    rst_n = 1;
    exp_mir = '0; exp_err = '0; exp_brk = 0; exp_halt = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    void'($urandom(32'h5eed_1234));
    exp_mir = '0; exp_err = '0; exp_brk = 0; exp_halt = 0;
    repeat (3) @(negedge clk);
    do_reset();
    // fill every entry cleanly
    for (int a = 0; a < DEPTH; a++)
      for (int s = 0; s < 2; s++) begin
        d = 16'($urandom);
        do_write(s[0], AW'(a), d, 1'($urandom), good_bpar(d), 1'b0);
      end
    // directed: clean fetch, no errors (R2)
    do_fetch(5'd3, 1'b0, 2'b11);
    check("R2 clean fetch no halt", 34'(halt), 34'(0));
    // R3: force upper only -> single error, no breakpoint, lower untouched
    d = 16'hA5C3;
    do_write(1'b1, 5'd7, d, 1'b1, good_bpar(d), 1'b1);
    do_fetch(5'd7, 1'b0, 2'b00);
    check("R3 upper only bad", 34'(err_latched), 34'(2'b10));
    // R7: both halves forced -> breakpoint
    do_write(1'b0, 5'd7, 16'h0F0F, 1'b0, good_bpar(16'h0F0F), 1'b1);
    do_fetch(5'd7, 1'b0, 2'b00);
    check("R7 breakpoint", 34'(brkpt), 34'(1));
    do_fetch(5'd3, 1'b0, 2'b00);
    check("R7 breakpoint clears", 34'(brkpt), 34'(0));
    // R8: hold mode keeps IR on bad fetch
    do_fetch(5'd7, 1'b1, 2'b00);
    check("R8 ir held", mir, {ref_d[1][3], ref_d[0][3]});
    // R1: write refused during fetch
    @(negedge clk);
    fetch_en = 1; fetch_addr = 5'd3; dbg_hold = 0; halt_en = 2'b00;
    wr_valid = 1; wr_sel = 1'b0; wr_addr = 5'd9; wr_data = ~ref_d[0][9][15:0];
    wr_bpar = 2'b00; wr_force_bad = 1;
    #1 check("R1 ready low in fetch", 34'(wr_ready), 34'(0));
    @(posedge clk);
    exp_mir = {ref_d[1][3], ref_d[0][3]}; exp_err = 2'b00; exp_brk = 0;
    @(negedge clk);
    wr_valid = 0; fetch_en = 0;
    #1 check("R1 ready high idle", 34'(wr_ready), 34'(1));
    do_fetch(5'd9, 1'b0, 2'b00);
    // R6: enabled lower half halts and stays
    d = 16'h1234;
    do_write(1'b0, 5'd11, d, 1'b0, good_bpar(d) ^ 2'b01, 1'b0);
    do_fetch(5'd11, 1'b0, 2'b10);
    check("R6 disabled half no halt", 34'(halt), 34'(0));
    do_fetch(5'd11, 1'b0, 2'b01);
    do_fetch(5'd3, 1'b0, 2'b00);
    check("R6 halt sticky", 34'(halt), 34'(1));
    do_reset();
    // random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 0) begin
        logic [1:0] bp;
        d = 16'($urandom);
        bp = good_bpar(d);
        if ($urandom_range(0, 9) == 0) bp ^= 2'($urandom_range(1, 3));
        do_write(1'($urandom), AW'($urandom), d, 1'($urandom), bp,
                 $urandom_range(0, 7) == 0);
      end else begin
        do_fetch(AW'($urandom), $urandom_range(0, 3) == 0,
                 ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00);
        if (exp_halt && $urandom_range(0, 3) == 0) do_reset();
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule